// File: doc/BRIEF.md
# Shared Interrupt Pin Controller with Backup-Mode Priority

This block decides the level of one active-low pin that a real-time clock shares between interrupt signalling, a static output level and a frequency-test clock. Three sources raise one-cycle event pulses: an alarm match, an oscillator failure and a watchdog timeout. Each pulse sets a sticky flag. The host clears a flag by writing a 0 to its bit. The host also writes enable bits, a static output level, a backup-interrupt enable and a frequency-test select through a small register bus, and it reads the flags back through the same bus.

A mode input tells the block whether the device runs on main power or on backup. On main power, the frequency-test select has first claim on the pin. After it come the enabled flags, and after them the static level. On backup, the pin follows a different chain. The backup enable is checked first, then the static level, then only the alarm and oscillator-fail sources. The pin is a register, and every change of flags, controls or mode shows on it one clock edge later.

Top module: `irq_out_ctrl`

## Requirements
- R1: After a synchronous reset, the pin is high, the static level is 1, the frequency-test select is 0, all enables are 0, the oscillator-fail flag is 1 and the other flags are 0. The read data bus is 0.
- R2: An event pulse sets its flag at the next edge, and the flag stays set until a bus write to the flag register carries a 0 in that bit position. Writing a 1 to a flag bit leaves the flag unchanged.
- R3: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: The register map is as follows. Address 0 holds bit 0 as the static level and bit 1 as the frequency-test select. Address 1 holds bit 0 as the alarm enable, bit 1 as the oscillator-fail enable, bit 2 as the watchdog enable and bit 3 as the backup enable. Address 2 holds the flags: bit 0 is alarm, bit 1 is oscillator fail and bit 2 is watchdog. Unused bits and address 3 read as 0 and ignore writes. Read data is registered and shows the state before the edge at which the address was sampled.
- R5: On backup, when the backup enable is 0, the pin is high whatever the level bit and the flags are.
- R6: On backup, when the backup enable is 1 and the level bit is 0, the pin is low whatever the flags are.
- R7: On backup, when the backup enable is 1 and the level bit is 1, the pin is low exactly when an enabled alarm flag or an enabled oscillator-fail flag is set. The watchdog source has no effect.
- R8: On backup, the frequency-test select has no effect on the pin.
- R9: On main power, when the frequency-test select is 1, the pin takes the value that the test clock input had at the previous edge.
- R10: On main power, when the frequency-test select is 0, the pin is low if any enabled flag is set. Otherwise the pin equals the level bit.
- R11: Once several enabled flags hold the pin low, the pin returns high only after the last of them has been cleared.
- R12: The mode input is sampled at the same edge as the pin is updated, so a change of mode shows on the pin at the next edge with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for bus_addr |
| evt_alarm | input | 1 | One-cycle alarm-match pulse |
| evt_osc_fail | input | 1 | One-cycle oscillator-failure pulse |
| evt_wdog | input | 1 | One-cycle watchdog-timeout pulse |
| on_backup | input | 1 | 1 when the device runs on backup supply |
| test_clk | input | 1 | Frequency-test clock to route to the pin |
| irq_pin_n | output | 1 | Registered active-low shared pin level |

## Verification
The bench builds the block with its defaults: a 2-bit address, which reaches all four addresses including the unused one, and an 8-bit data path, whose upper bits exercise the rule that unused bits are ignored and read as zero. With these widths, random writes reach every combination of level bit, backup enable, test select and source enables in both modes. The random event pulses then land on set, held and cleared flags in every priority branch. Directed sequences force the set-versus-clear collision, the release of a pin held by two flags, and mode switches while a watchdog flag that backup mode must ignore is pending.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;
  // Interrupt sources, indexed in the flag and enable vectors
  localparam int NSRC      = 3;
  localparam int SRC_ALARM = 0;
  localparam int SRC_OSC   = 1;
  localparam int SRC_WDOG  = 2;

  // Sources allowed to pull the pin while on backup supply
  localparam logic [NSRC-1:0] BKUP_SRC_MASK = 3'b011;

  // Flag values after reset: oscillator fail starts set
  localparam logic [NSRC-1:0] FLAG_RST = 3'b010;

  // Register addresses
  localparam int ADDR_OUTCTL = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_FLAGS  = 2;

  // Bit positions inside the control registers
  localparam int OUTCTL_LVL_BIT   = 0;
  localparam int OUTCTL_FTEST_BIT = 1;
  localparam int ENABLE_BKUP_BIT  = NSRC;

  typedef struct packed {
    logic            bk_en;
    logic [NSRC-1:0] src_en;
    logic            out_lvl;
    logic            ftest;
  } ctrl_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_q[i] <= RST_VAL[i];
      else if (set_i[i]) flag_q[i] <= 1'b1;   // set has priority
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    // R2 / R3: a pulse always leaves the flag set, even with a clear
    p_event_sets_r3: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_q[i]);

    // R2: a set flag with no clearing write stays set
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_out_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   flags_i,
  output ctrl_t             ctrl_o,
  output logic [NSRC-1:0]   flag_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int USED_W = NSRC + 1;

  logic wr_outctl, wr_enable, wr_flags;
  logic unused_wbits;

  assign wr_outctl    = wr_i && (addr_i == ADDR_W'(ADDR_OUTCTL));
  assign wr_enable    = wr_i && (addr_i == ADDR_W'(ADDR_ENABLE));
  assign wr_flags     = wr_i && (addr_i == ADDR_W'(ADDR_FLAGS));
  assign unused_wbits = ^wdata_i[DATA_W-1:USED_W];

  // Writing 0 to a flag bit requests a clear; writing 1 does nothing
  assign flag_clr_o = {NSRC{wr_flags}} & ~wdata_i[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o.out_lvl <= 1'b1;
      ctrl_o.ftest   <= 1'b0;
      ctrl_o.src_en  <= '0;
      ctrl_o.bk_en   <= 1'b0;
    end else begin
      if (wr_outctl) begin
        ctrl_o.out_lvl <= wdata_i[OUTCTL_LVL_BIT];
        ctrl_o.ftest   <= wdata_i[OUTCTL_FTEST_BIT];
      end
      if (wr_enable) begin
        ctrl_o.src_en <= wdata_i[NSRC-1:0];
        ctrl_o.bk_en  <= wdata_i[ENABLE_BKUP_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      case (addr_i)
        ADDR_W'(ADDR_OUTCTL): begin
          rdata_o[OUTCTL_LVL_BIT]   <= ctrl_o.out_lvl;
          rdata_o[OUTCTL_FTEST_BIT] <= ctrl_o.ftest;
        end
        ADDR_W'(ADDR_ENABLE): begin
          rdata_o[NSRC-1:0]       <= ctrl_o.src_en;
          rdata_o[ENABLE_BKUP_BIT] <= ctrl_o.bk_en;
        end
        ADDR_W'(ADDR_FLAGS): rdata_o[NSRC-1:0] <= flags_i;
        default: ;
      endcase
    end
  end

  // R4: a write to the level register lands in the control state
  p_outctl_write_r4: assert property (@(posedge clk) disable iff (rst)
    wr_outctl |=> (ctrl_o.out_lvl == $past(wdata_i[OUTCTL_LVL_BIT])));

  // R4: enable register holds its value when not written
  p_enable_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_enable |=> $stable(ctrl_o.src_en));
endmodule

// File: rtl/irq_pin_sel.sv
module irq_pin_sel
  import irq_out_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            on_backup_i,
  input  logic            test_clk_i,
  input  ctrl_t           ctrl_i,
  input  logic [NSRC-1:0] flags_i,
  output logic            pin_n_o
);
  logic hit_main, hit_bkup, pin_nxt;

  assign hit_main = |(ctrl_i.src_en & flags_i);
  assign hit_bkup = |(ctrl_i.src_en & flags_i & BKUP_SRC_MASK);

  always_comb begin
    if (on_backup_i) begin
      if (!ctrl_i.bk_en)        pin_nxt = 1'b1;
      else if (!ctrl_i.out_lvl) pin_nxt = 1'b0;
      else                      pin_nxt = !hit_bkup;
    end else begin
      if (ctrl_i.ftest)         pin_nxt = test_clk_i;
      else if (hit_main)        pin_nxt = 1'b0;
      else                      pin_nxt = ctrl_i.out_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_n_o <= 1'b1;
    else     pin_n_o <= pin_nxt;
  end

  // R5: backup enable off forces the pin high
  p_bkup_off_high_r5: assert property (@(posedge clk) disable iff (rst)
    (on_backup_i && !ctrl_i.bk_en) |=> pin_n_o);

  // R6: backup with level bit 0 forces the pin low
  p_bkup_lvl_low_r6: assert property (@(posedge clk) disable iff (rst)
    (on_backup_i && ctrl_i.bk_en && !ctrl_i.out_lvl) |=> !pin_n_o);

  // R7: watchdog alone never pulls the pin on backup
  p_bkup_wdog_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (on_backup_i && ctrl_i.bk_en && ctrl_i.out_lvl &&
     !flags_i[SRC_ALARM] && !flags_i[SRC_OSC]) |=> pin_n_o);

  // R10: an enabled flag on main power without test select pulls low
  p_main_flag_low_r10: assert property (@(posedge clk) disable iff (rst)
    (!on_backup_i && !ctrl_i.ftest && hit_main) |=> !pin_n_o);

  // R9: test select on main power passes the test clock
  p_main_ftest_r9: assert property (@(posedge clk) disable iff (rst)
    (!on_backup_i && ctrl_i.ftest) |=> (pin_n_o == $past(test_clk_i)));
endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl
  import irq_out_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_alarm,
  input  logic              evt_osc_fail,
  input  logic              evt_wdog,
  input  logic              on_backup,
  input  logic              test_clk,
  output logic              irq_pin_n
);
  ctrl_t           ctrl;
  logic [NSRC-1:0] flags, flag_set, flag_clr;

  always_comb begin
    flag_set            = '0;
    flag_set[SRC_ALARM] = evt_alarm;
    flag_set[SRC_OSC]   = evt_osc_fail;
    flag_set[SRC_WDOG]  = evt_wdog;
  end

  irq_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .flags_i    (flags),
    .ctrl_o     (ctrl),
    .flag_clr_o (flag_clr),
    .rdata_o    (bus_rdata)
  );

  irq_flag_bank #(.N(NSRC), .RST_VAL(FLAG_RST)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_q (flags)
  );

  irq_pin_sel u_pin (
    .clk         (clk),
    .rst         (rst),
    .on_backup_i (on_backup),
    .test_clk_i  (test_clk),
    .ctrl_i      (ctrl),
    .flags_i     (flags),
    .pin_n_o     (irq_pin_n)
  );

  // R1: the pin leaves reset high
  p_reset_pin_high_r1: assert property (@(posedge clk)
    $past(rst) |-> irq_pin_n);
endmodule

// File: tb/irq_out_ctrl_tb.sv
module irq_out_ctrl_tb;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic evt_alarm = 1'b0, evt_osc_fail = 1'b0, evt_wdog = 1'b0;
  logic on_backup = 1'b0, test_clk = 1'b0;
  logic irq_pin_n;

  int checks = 0;
  int fails  = 0;
  int seed_dummy;

  // Bench model state
  logic       m_lvl, m_ft, m_bk, prev_mode;
  logic [2:0] m_en, m_fl;

  always #4 clk = ~clk;

  irq_out_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_alarm(evt_alarm),
    .evt_osc_fail(evt_osc_fail), .evt_wdog(evt_wdog), .on_backup(on_backup),
    .test_clk(test_clk), .irq_pin_n(irq_pin_n)
  );

  function automatic logic exp_pin();
    if (on_backup) begin
      if (!m_bk)  return 1'b1;
      if (!m_lvl) return 1'b0;
      return !((m_en[0] & m_fl[0]) | (m_en[1] & m_fl[1]));
    end
    if (m_ft) return test_clk;
    if (|(m_en & m_fl)) return 1'b0;
    return m_lvl;
  endfunction

  function automatic string pin_rule();
    string t;
    if (on_backup) t = !m_bk ? "R5" : (!m_lvl ? "R6" : "R7");
    else           t = m_ft ? "R9" : "R10";
    if (on_backup && m_ft) t = {t, "/R8"};
    if (on_backup != prev_mode) t = {t, "/R12"};
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] exp_rdata();
    case (bus_addr)
      2'd0: return {6'b0, m_ft, m_lvl};
      2'd1: return {4'b0, m_bk, m_en};
      2'd2: return {5'b0, m_fl};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: inputs already driven; compute expectations, advance, compare
  task automatic step(input string rtag = "R4", input string ptag = "");
    logic       ep;
    logic [DATA_W-1:0] er;
    string      pt;
    logic [2:0] evt;
    ep  = exp_pin();
    er  = exp_rdata();
    pt  = (ptag == "") ? pin_rule() : ptag;
    evt = {evt_wdog, evt_osc_fail, evt_alarm};
    @(posedge clk);
    #2;
    check(pt, {7'b0, irq_pin_n}, {7'b0, ep});
    check(rtag, bus_rdata, er);
    for (int i = 0; i < 3; i++) begin
      if (evt[i]) m_fl[i] = 1'b1;
      else if (bus_wr && bus_addr == 2'd2 && !bus_wdata[i]) m_fl[i] = 1'b0;
    end
    if (bus_wr && bus_addr == 2'd0) begin m_lvl = bus_wdata[0]; m_ft = bus_wdata[1]; end
    if (bus_wr && bus_addr == 2'd1) begin m_en = bus_wdata[2:0]; m_bk = bus_wdata[3]; end
    prev_mode = on_backup;
    @(negedge clk);
    bus_wr = 1'b0; evt_alarm = 1'b0; evt_osc_fail = 1'b0; evt_wdog = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    bus_addr = a;
    step(tag);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h1bad5eed);
    m_lvl = 1'b1; m_ft = 1'b0; m_bk = 1'b0; m_en = '0; m_fl = 3'b010;
    prev_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values through pin and register reads
    check("R1", {7'b0, irq_pin_n}, 8'h01);
    check("R1", bus_rdata, 8'h00);
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");

    // R2: write 1 keeps flags, write 0 clears, pulse sets
    wr(2'd2, 8'hFF); rd(2'd2, "R2");
    wr(2'd2, 8'h00); rd(2'd2, "R2");
    evt_wdog = 1'b1; step(); rd(2'd2, "R2");
    // R3: pulse and clearing write on the same cycle
    evt_alarm = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h00;
    step(); rd(2'd2, "R3");
    // R4: upper bits ignored and address 3 reads zero
    wr(2'd1, 8'hF0); rd(2'd1, "R4");
    wr(2'd3, 8'hFF); rd(2'd3, "R4");

    // R11: two enabled flags hold the pin, clear one at a time
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h07);
    evt_alarm = 1'b1; evt_wdog = 1'b1; step();
    step("R4", "R11");
    wr(2'd2, 8'h04); step("R4", "R11");
    wr(2'd2, 8'h00); step("R4", "R11");

    // R7 / R12: backup ignores a pending watchdog flag
    evt_wdog = 1'b1; step();
    wr(2'd1, 8'h0F);
    on_backup = 1'b1; step(); step();
    on_backup = 1'b0; step(); step();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 29) == 0) on_backup = ~on_backup;
      test_clk     = 1'($urandom_range(0, 1));
      evt_alarm    = ($urandom_range(0, 9) == 0);
      evt_osc_fail = ($urandom_range(0, 11) == 0);
      evt_wdog     = ($urandom_range(0, 9) == 0);
      bus_addr     = 2'($urandom_range(0, 3));
      bus_wdata    = 8'($urandom_range(0, 255));
      bus_wr       = ($urandom_range(0, 5) == 0);
      step();
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule